// File: doc/BRIEF.md
# PCM Serial Port with Frame Autodetect

This block is the digital serial side of a voice codec channel. Once per 8 kHz frame it sends one 16-bit two's-complement word on the transmit line and receives one on the receive line, both clocked by a bit clock running at 32 or 64 times the frame rate. Only the first 16-bit slot of each frame is used. Outside that slot the transmit output enable is low, so the line can be shared or left floating. The parallel side takes a 14-bit transmit sample and returns a 14-bit received sample with a one-cycle valid strobe.

The port measures how long the frame sync stays high, counted in falling bit-clock edges, and uses the result to choose between two formats. In the long format, the sync pulse covers the first data bits. In the short format, a one-bit sync pulse comes one bit before the word. The measured format is shown on a status output and sets the timing of the next frame. A mute input blanks the transmit slot starting from the next frame start and forces the received sample to zero.

The transmit line changes on rising bit-clock edges. The receive line and the sync are sampled on falling edges.

Top module: `pcm_serial_port`

## Requirements
- R1: The transmitted word is the 14-bit sample MSB first, followed by two bits that are always 0, one bit per rising edge of `bclk`.
- R2: The received sample equals the upper 14 bits of the 16 captured receive bits; the last two captured bits have no effect on `rx_sample`.
- R3: `long_frame` is 1 after reset. It is updated on the first falling edge that samples `fs` low after a high pulse: it becomes 1 if that pulse was sampled high on 2 or more falling edges, and 0 if on exactly 1.
- R4: With `long_frame`=1, the slot starts on the first rising edge at which `fs` is high after being low on the previous rising edge. With `long_frame`=0, the slot starts on the rising edge that follows the falling edge that first sampled `fs` high. A frame uses the `long_frame` value in force when its slot starts; a sync pulse seen during a slot does not restart it.
- R5: `dx_oe` is high for exactly 16 consecutive `bclk` cycles per frame and low for the rest of the frame, whether the frame is 32 or 64 cycles long.
- R6: Receive bit k of the word is taken from `dr` on the falling edge that follows the rising edge which put transmit bit k on `dx`.
- R7: A frame whose slot starts while `mute_n`=0 keeps `dx_oe` low for the whole frame. A change of `mute_n` after the slot has started does not change `dx_oe` or `dx` until the next slot start.
- R8: If `mute_n` is 0 on the falling edge that captures the 16th receive bit, the latched `rx_sample` is all zeros.
- R9: `rx_valid` goes high on the falling edge that captures the 16th receive bit and stays high for exactly one `bclk` cycle.
- R10: While `rst_n` is low: `dx_oe`=0, `dx`=0, `rx_valid`=0, `rx_sample`=0, and `long_frame`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock, 32 or 64 cycles per frame |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame sync |
| dr | input | 1 | Serial receive data |
| mute_n | input | 1 | 0 = mute the transmit slot and zero the received sample |
| tx_sample | input | 14 | Two's-complement sample to send, taken at slot start |
| dx | output | 1 | Serial transmit data, valid while `dx_oe` is 1 |
| dx_oe | output | 1 | Output enable for the transmit line |
| rx_sample | output | 14 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when `rx_sample` is updated |
| long_frame | output | 1 | Detected format: 1 = long sync, 0 = short sync |

## Verification
The bench sends several kinds of transmit sample: zero, both full-scale extremes, a mid-scale value and a walking one over all 14 bit positions. The walking one shows whether bit order and bit position are right on `dx`. The receive words carry set bits in the two bits that are dropped, and the `dr` bits outside the slot are driven with filler, so a mistake in stripping or capture alignment shows up as a wrong sample. Both sync formats are run at 32 and at 64 cycles per frame, including a pulse of exactly two cycles and the frames where the format switches, so the bench can see that a frame uses the previously detected schedule. Mute is applied before a frame, dropped in the middle of a word and then released, which separates the effect on the transmit slot (applied at the frame boundary) from the effect on the received sample (applied when the word is latched).

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_LONG  = 1'b1
  } frame_fmt_e;

  // Choose the frame format from the number of falling edges at which the sync was seen high.
  function automatic frame_fmt_e classify_width(input int unsigned hi_cycles,
                                                input int unsigned long_min);
    return (hi_cycles >= long_min) ? FMT_LONG : FMT_SHORT;
  endfunction

endpackage

// File: rtl/pcm_fs_detect.sv
module pcm_fs_detect
  import pcm_port_pkg::*;
#(
  parameter int unsigned LONG_MIN = 2
) (
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       fs,
  output logic       fs_smp,
  output logic       width_done,
  output frame_fmt_e fmt
);

  localparam int unsigned CNT_W = $clog2(LONG_MIN + 1);

  logic [CNT_W-1:0] hi_cnt;

  // Count up, but stop at LONG_MIN: beyond it the length no longer matters.
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c >= CNT_W'(LONG_MIN)) ? c : c + 1'b1;
  endfunction

  // The first low sample after a high pulse ends the measurement.
  assign width_done = fs_smp & ~fs;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_smp <= 1'b0;
      hi_cnt <= '0;
      fmt    <= FMT_LONG;
    end else begin
      fs_smp <= fs;
      if (fs) begin
        hi_cnt <= fs_smp ? bump(hi_cnt) : CNT_W'(1);
      end else if (fs_smp) begin
        fmt <= classify_width(32'(hi_cnt), LONG_MIN);
      end
    end
  end

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_port_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned WORD_W   = 16
) (
  input  logic                       bclk,
  input  logic                       rst_n,
  input  logic                       fs,
  input  logic                       fs_smp,
  input  frame_fmt_e                 fmt,
  input  logic                       mute_n,
  input  logic [SAMPLE_W-1:0]        tx_sample,
  output logic                       dx,
  output logic                       dx_oe,
  output logic                       busy,
  output logic [$clog2(WORD_W)-1:0]  bit_idx,
  output logic                       frame_start
);

  localparam int unsigned PAD_W = WORD_W - SAMPLE_W;
  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic              fs_pq;
  logic              smp_pq;
  logic              mute_frame;
  logic              long_go;
  logic              short_go;
  logic [WORD_W-1:0] shreg;

  // The sample goes in the upper bits; the padding bits below it are zero.
  function automatic logic [WORD_W-1:0] pad_word(input logic [SAMPLE_W-1:0] s);
    return {s, {PAD_W{1'b0}}};
  endfunction

  // Long format: the sync is seen high at a rising edge.
  // Short format: the sync was first seen high at the previous falling edge.
  assign long_go     = fs & ~fs_pq;
  assign short_go    = fs_smp & ~smp_pq;
  assign frame_start = ~busy & ((fmt == FMT_LONG) ? long_go : short_go);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_pq      <= 1'b0;
      smp_pq     <= 1'b0;
      busy       <= 1'b0;
      bit_idx    <= '0;
      shreg      <= '0;
      mute_frame <= 1'b0;
    end else begin
      fs_pq  <= fs;
      smp_pq <= fs_smp;
      if (frame_start) begin
        busy       <= 1'b1;
        bit_idx    <= '0;
        shreg      <= pad_word(tx_sample);
        mute_frame <= ~mute_n;
      end else if (busy) begin
        shreg <= {shreg[WORD_W-2:0], 1'b0};
        if (bit_idx == LAST) begin
          busy <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  assign dx_oe = busy & ~mute_frame;
  assign dx    = dx_oe & shreg[WORD_W-1];

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned WORD_W   = 16
) (
  input  logic                       bclk,
  input  logic                       rst_n,
  input  logic                       dr,
  input  logic                       busy,
  input  logic [$clog2(WORD_W)-1:0]  bit_idx,
  input  logic                       mute_n,
  output logic [SAMPLE_W-1:0]        rx_sample,
  output logic                       rx_valid,
  output logic                       word_done
);

  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  // Holds the first WORD_W-1 bits. The last bit, still on dr, is one of the dropped padding bits.
  logic [WORD_W-2:0] acc;

  assign word_done = busy && (bit_idx == LAST);

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      rx_valid  <= 1'b0;
      rx_sample <= '0;
    end else begin
      rx_valid <= word_done;
      if (busy) begin
        acc <= {acc[WORD_W-3:0], dr};
      end
      if (word_done) begin
        rx_sample <= mute_n ? acc[WORD_W-2 -: SAMPLE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned LONG_MIN = 2
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                fs,
  input  logic                dr,
  input  logic                mute_n,
  input  logic [SAMPLE_W-1:0] tx_sample,
  output logic                dx,
  output logic                dx_oe,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic                rx_valid,
  output logic                long_frame
);

  localparam int unsigned IDX_W = $clog2(WORD_W);

  // Internal events, brought out as named wires for the checker.
  logic             fs_smp;
  logic             width_done;
  logic             frame_start;
  logic             word_done;
  logic             busy;
  logic [IDX_W-1:0] bit_idx;
  frame_fmt_e       fmt;

  pcm_fs_detect #(
    .LONG_MIN(LONG_MIN)
  ) u_detect (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .fs        (fs),
    .fs_smp    (fs_smp),
    .width_done(width_done),
    .fmt       (fmt)
  );

  pcm_tx_slot #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W)
  ) u_tx (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .fs         (fs),
    .fs_smp     (fs_smp),
    .fmt        (fmt),
    .mute_n     (mute_n),
    .tx_sample  (tx_sample),
    .dx         (dx),
    .dx_oe      (dx_oe),
    .busy       (busy),
    .bit_idx    (bit_idx),
    .frame_start(frame_start)
  );

  pcm_rx_slot #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W)
  ) u_rx (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .dr       (dr),
    .busy     (busy),
    .bit_idx  (bit_idx),
    .mute_n   (mute_n),
    .rx_sample(rx_sample),
    .rx_valid (rx_valid),
    .word_done(word_done)
  );

  assign long_frame = (fmt == FMT_LONG);

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned WORD_W   = 16
) (
  input logic                       bclk,
  input logic                       rst_n,
  input logic                       fs,
  input logic                       fs_smp,
  input logic                       mute_n,
  input logic                       dx,
  input logic                       dx_oe,
  input logic                       busy,
  input logic [$clog2(WORD_W)-1:0]  bit_idx,
  input logic                       rx_valid,
  input logic [SAMPLE_W-1:0]        rx_sample,
  input logic                       long_frame
);

  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam int unsigned RUN_W = $clog2(WORD_W + 2);

  logic [RUN_W-1:0] oe_run;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= dx_oe ? oe_run + 1'b1 : '0;
  end

  // R1
  tail_low_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (dx_oe && bit_idx >= IDX_W'(SAMPLE_W)) |-> !dx);

  // R5
  oe_in_slot_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    dx_oe |-> busy);

  // R5
  oe_length_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    $fell(dx_oe) |-> (oe_run == RUN_W'(WORD_W)));

  // R7
  mute_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dx_oe));

  // R9
  valid_pulse_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  mute_zero_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    (rx_valid && !$past(mute_n)) |-> (rx_sample == '0));

  // R3
  fmt_update_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    !$stable(long_frame) |-> ($past(fs_smp) && !$past(fs)));

endmodule

bind pcm_serial_port pcm_serial_port_chk #(
  .SAMPLE_W(SAMPLE_W),
  .WORD_W  (WORD_W)
) u_chk (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .fs        (fs),
  .fs_smp    (fs_smp),
  .mute_n    (mute_n),
  .dx        (dx),
  .dx_oe     (dx_oe),
  .busy      (busy),
  .bit_idx   (bit_idx),
  .rx_valid  (rx_valid),
  .rx_sample (rx_sample),
  .long_frame(long_frame)
);

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        dr = 1'b0;
  logic        mute_n = 1'b1;
  logic [13:0] tx_sample = '0;
  logic        dx;
  logic        dx_oe;
  logic [13:0] rx_sample;
  logic        rx_valid;
  logic        long_frame;

  int checks = 0;
  int errors = 0;
  bit cur_long = 1'b1;   // format detected so far, as the bench models it
  logic drv [0:63];

  always #10 bclk = ~bclk;

  pcm_serial_port u0 (
    .bclk(bclk), .rst_n(rst_n), .fs(fs), .dr(dr), .mute_n(mute_n),
    .tx_sample(tx_sample), .dx(dx), .dx_oe(dx_oe), .rx_sample(rx_sample),
    .rx_valid(rx_valid), .long_frame(long_frame)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Expects to be entered 5 ns after a falling edge.
  // mute: mute_n low from cycle 0; drop_at >= 0: mute_n goes low from that cycle on.
  task automatic run_frame(input bit lng, input int hi_len, input int nb,
                           input logic [13:0] tx, input logic [15:0] rxw,
                           input bit mute, input int drop_at);
    int s;
    int d0;
    bit fmute;
    bit lmute;
    logic [15:0] word;
    logic [15:0] cap;
    s     = cur_long ? 0 : 1;   // R4: schedule from the format detected earlier
    d0    = lng ? 0 : 1;
    word  = {tx, 2'b00};        // R1
    fmute = mute || (drop_at >= 0 && s >= drop_at);
    lmute = mute || (drop_at >= 0 && s + 15 >= drop_at);
    tx_sample = tx;
    for (int c = 0; c < nb; c++) begin
      fs = lng ? (c < hi_len) : (c == 0);
      dr = (c >= d0 && c < d0 + 16) ? rxw[15 - (c - d0)] : (c[0] ^ c[2]);
      drv[c] = dr;
      mute_n = !(mute || (drop_at >= 0 && c >= drop_at));
      @(posedge bclk); #5;
      begin
        bit exp_oe;
        exp_oe = !fmute && c >= s && c < s + 16;
        chk("R5/R7 dx_oe", 32'(dx_oe), 32'(exp_oe));
        if (exp_oe) chk("R1 dx bit", 32'(dx), 32'(word[15 - (c - s)]));
      end
      chk("R9 rx_valid", 32'(rx_valid), 32'(c == s + 16));
      if (c == s + 16) begin
        for (int k = 0; k < 16; k++) cap[15 - k] = drv[s + k];   // R6
        chk("R2/R6/R8 rx_sample", 32'(rx_sample), lmute ? 32'd0 : 32'(cap[15:2]));
      end
      @(negedge bclk); #5;
    end
    cur_long = lng && hi_len >= 2;
    // R3
    chk("R3 long_frame", 32'(long_frame), 32'(cur_long));
  endtask

  initial begin
    #(64'd200000 * 20);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] pats [0:3];
    pats[0] = 14'h0000; pats[1] = 14'h1FFF; pats[2] = 14'h2000; pats[3] = 14'h164A;
    repeat (3) @(posedge bclk);
    #5;
    // R10
    chk("R10 dx_oe", 32'(dx_oe), 0);
    chk("R10 dx", 32'(dx), 0);
    chk("R10 rx_valid", 32'(rx_valid), 0);
    chk("R10 rx_sample", 32'(rx_sample), 0);
    chk("R10 long_frame", 32'(long_frame), 1);
    @(negedge bclk); #5;
    rst_n = 1'b1;
    repeat (3) @(negedge bclk);
    #5;
    // R1 R2 R4: long format, extreme and mid-scale samples
    for (int i = 0; i < 4; i++)
      run_frame(1'b1, 8, 32, pats[i], {~pats[i], 2'b11}, 1'b0, -1);
    // R3: two-cycle pulse is still long, 64-cycle frame
    run_frame(1'b1, 2, 64, 14'h0A5C, 16'hC3A5, 1'b0, -1);
    // R4: switch to short; first frame still on the long schedule
    run_frame(1'b0, 1, 32, 14'h1234, 16'h5A5B, 1'b0, -1);
    // R1 R2 walking one, short format, 32 and 64 cycles
    for (int i = 0; i < 14; i++)
      run_frame(1'b0, 1, (i % 2) ? 64 : 32, 14'(1 << i),
                {14'(1 << (13 - i)), 2'b10}, 1'b0, -1);
    // R4: back to long, transition frame on the short schedule
    run_frame(1'b1, 4, 32, 14'h2AAA, 16'h9667, 1'b0, -1);
    for (int i = 0; i < 14; i++)
      run_frame(1'b1, 3, (i % 2) ? 32 : 64, 14'(1 << i),
                {14'(1 << i), 2'b01}, 1'b0, -1);
    // R7 R8: mute dropped mid-word, then muted frame, then released
    run_frame(1'b1, 8, 32, 14'h3C3C, 16'hFFFF, 1'b0, 6);
    run_frame(1'b1, 8, 32, 14'h1FFF, 16'h7FFF, 1'b1, -1);
    run_frame(1'b1, 8, 32, 14'h0F0F, 16'h8001, 1'b0, -1);
    // R7 R8 in short format
    run_frame(1'b0, 1, 64, 14'h0001, 16'h0004, 1'b0, -1);
    run_frame(1'b0, 1, 32, 14'h3FFF, 16'hFFFC, 1'b0, 10);
    run_frame(1'b0, 1, 32, 14'h2001, 16'h4005, 1'b0, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule